// File: doc/BRIEF.md
# Auto-Negotiation Link Timer and Completion Interrupt

This block measures the link interval that an auto-negotiation state machine waits through, and it raises a completion interrupt for software. A prescaler runs freely from reset and gives one coarse tick every 2^PRESCALE_W clock cycles. With the default 12-bit prescaler and a 125 MHz clock, a tick lasts 32.768 µs. A 9-bit length, sampled on each start, sets how many ticks the timer counts down. A length of 317 gives an interval of about 10.35 to 10.39 ms, which suits 1000BASE-X. A much smaller length shortens simulation.

The negotiation state machine pulses a start input to load the timer. It may pulse start again at any time to reload the count. At the end of the interval the block returns a one-cycle done pulse and then stays idle until the next start. Because the tick runs freely, the real interval is between L-1 and L ticks for a programmed length L.

A two-bit control register holds the interrupt settings. Bit 0 enables the interrupt. Bit 1 is the pending status, which software clears by writing zero to it. The interrupt output follows the status bit, and it stays low while the interrupt is disabled.

Top module: `an_link_timer`

## Requirements
- R1: After a start pulse sampled at clock edge E0 with length L ≥ 1, `link_done` is first high after clock edge Ej, with j in the range (L-1)·2^PRESCALE_W+1 to L·2^PRESCALE_W.
- R2: A length of 0 acts like a length of 1: `link_done` goes high after one of the first 2^PRESCALE_W edges that follow the start edge.
- R3: `link_done` is high for exactly one cycle per expiry. After that the timer stays idle and gives no further `link_done` until the next start.
- R4: A start pulse while the timer runs reloads the length at once, and the interval is measured from that restart. No expiry from the earlier start appears.
- R5: After reset, `link_done`, `an_irq` and `cfg_rdata` are all 0.
- R6: A write with `cfg_we` high sets the enable from `cfg_wdata[0]`. `cfg_rdata` reads back {status (bit 1), enable (bit 0)}.
- R7: While the interrupt is disabled, `an_irq` is 0 and `an_done` pulses have no effect. A write with `cfg_wdata[0]` = 0 clears a pending status.
- R8: While the interrupt is enabled, an `an_done` pulse sets the status bit, and `an_irq` is high from the next clock edge on.
- R9: The status bit is sticky. A write with bit 1 = 1 leaves it as it is, and a write with bit 1 = 0 clears it. An `an_done` pulse in the same cycle as such a clear keeps the status set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_len | input | 9 | Timer length in ticks, sampled on start |
| link_start | input | 1 | Start or restart pulse from the negotiation state machine |
| link_done | output | 1 | One-cycle expiry pulse |
| an_done | input | 1 | Pulse marking a completed negotiation cycle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Write data: bit 1 status (write 0 to clear), bit 0 enable |
| cfg_rdata | output | 2 | Read data: bit 1 status, bit 0 enable |
| an_irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions take for granted that `an_done` and `link_start` are single-cycle pulses. They also assume that a control write counts as a possible clear only when its bit 1 is zero. The stickiness and set properties are therefore stated only for cycles without a write. The bench drives every stimulus as an isolated one-cycle pulse at the falling edge. It lets the prescaler phase drift between timer runs by inserting idle gaps of different lengths. This keeps each expiry check within the tick-uncertainty window that R1 defines.

// File: rtl/an_link_timer.sv
module an_link_timer #(
  parameter int PRESCALE_W = 12,
  parameter int LEN_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] link_len,
  input  logic             link_start,
  output logic             link_done,
  input  logic             an_done,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_wdata,
  output logic [1:0]       cfg_rdata,
  output logic             an_irq
);

  localparam logic [PRESCALE_W-1:0] PRE_MAX = '1;
  localparam logic [LEN_W-1:0]      ONE     = LEN_W'(1);

  logic [PRESCALE_W-1:0] pre_q;
  logic [LEN_W-1:0]      cnt_q;
  logic                  run_q, done_q, en_q, stat_q;

  wire tick    = (pre_q == PRE_MAX);
  wire last    = (cnt_q <= ONE);
  wire en_nx   = cfg_we ? cfg_wdata[0] : en_q;
  wire clr     = cfg_we & ~cfg_wdata[1];
  wire stat_nx = en_nx & ((stat_q & ~clr) | an_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (link_start) begin
      cnt_q  <= link_len;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q && tick) begin
      if (last) begin
        cnt_q  <= '0;
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_nx;
      stat_q <= stat_nx;
    end

  assign link_done = done_q;
  assign an_irq    = stat_q;
  assign cfg_rdata = {stat_q, en_q};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> !link_done); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !link_start) |=> !link_done); // R3
  AST_IRQ_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !an_irq); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && en_q && !cfg_we) |=> an_irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (an_irq && !cfg_we) |=> an_irq); // R9
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && cfg_we && cfg_wdata[0]) |=> an_irq); // R9

endmodule

// File: tb/test_an_link_timer.sv
module test_an_link_timer;
  localparam int PW = 4;
  localparam int TK = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] link_len = '0;
  logic       link_start = 1'b0;
  logic       link_done;
  logic       an_done = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_rdata;
  logic       an_irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  an_link_timer #(.PRESCALE_W(PW), .LEN_W(9)) i_an_link_timer (
    .clk(clk), .rst_n(rst_n), .link_len(link_len), .link_start(link_start),
    .link_done(link_done), .an_done(an_done), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .an_irq(an_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] d, input logic cmp);
    cfg_we = 1'b1; cfg_wdata = d; an_done = cmp;
    @(negedge clk);
    cfg_we = 1'b0; an_done = 1'b0;
  endtask

  task automatic pulse_an;
    an_done = 1'b1;
    @(negedge clk);
    an_done = 1'b0;
  endtask

  task automatic measure(input int len, input string req);
    int n, lo, hi, eff;
    eff = (len == 0) ? 1 : len;
    lo = (eff - 1) * TK + 1;
    hi = eff * TK;
    link_len = 9'(len); link_start = 1'b1;
    @(negedge clk);
    link_start = 1'b0;
    n = 0;
    while (!link_done && n < 520 * TK) begin
      @(negedge clk);
      n++;
    end
    chk(n >= lo && n <= hi, req, n, hi);
    @(negedge clk);
    chk(!link_done, "R3 pulse width", int'(link_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int quiet;
    repeat (3) @(negedge clk);
    chk(!link_done && !an_irq && cfg_rdata == 2'b00, "R5 reset", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!link_done && !an_irq && cfg_rdata == 2'b00, "R5 after release", int'(cfg_rdata), 0);

    for (int l = 1; l <= 40; l++) begin
      measure(l, "R1 expiry window");
      repeat (l % 7) @(negedge clk);
    end
    measure(0, "R2 zero length");
    measure(0, "R2 zero length again");
    measure(511, "R1 max length");

    quiet = 0;
    for (int i = 0; i < 5 * TK; i++) begin
      @(negedge clk);
      quiet += int'(link_done);
    end
    chk(quiet == 0, "R3 stays idle", quiet, 0);

    link_len = 9'd20; link_start = 1'b1;
    @(negedge clk);
    link_start = 1'b0;
    quiet = 0;
    for (int i = 0; i < 3 * TK; i++) begin
      @(negedge clk);
      quiet += int'(link_done);
    end
    chk(quiet == 0, "R4 no early done", quiet, 0);
    measure(3, "R4 restart window");
    quiet = 0;
    for (int i = 0; i < 25 * TK; i++) begin
      @(negedge clk);
      quiet += int'(link_done);
    end
    chk(quiet == 0, "R4 old start discarded", quiet, 0);

    pulse_an;
    @(negedge clk);
    chk(!an_irq && cfg_rdata == 2'b00, "R7 ignored when disabled", int'(cfg_rdata), 0);
    wr(2'b01, 1'b0);
    chk(cfg_rdata == 2'b01 && !an_irq, "R6 enable readback", int'(cfg_rdata), 1);
    pulse_an;
    chk(an_irq && cfg_rdata == 2'b11, "R8 set on completion", int'(cfg_rdata), 3);
    repeat (10) @(negedge clk);
    chk(an_irq, "R9 sticky", int'(an_irq), 1);
    wr(2'b11, 1'b0);
    chk(an_irq && cfg_rdata == 2'b11, "R9 write one keeps", int'(cfg_rdata), 3);
    wr(2'b01, 1'b0);
    chk(!an_irq && cfg_rdata == 2'b01, "R9 write zero clears", int'(cfg_rdata), 1);
    wr(2'b01, 1'b1);
    chk(an_irq && cfg_rdata == 2'b11, "R9 completion beats clear", int'(cfg_rdata), 3);
    wr(2'b00, 1'b0);
    chk(!an_irq && cfg_rdata == 2'b00, "R7 disable clears", int'(cfg_rdata), 0);
    wr(2'b10, 1'b1);
    chk(!an_irq && cfg_rdata == 2'b00, "R7 disabled write ignores completion", int'(cfg_rdata), 0);
    wr(2'b01, 1'b1);
    chk(an_irq && cfg_rdata == 2'b11, "R8 enable with completion", int'(cfg_rdata), 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule